// File: doc/BRIEF.md
# Periodic and Mains Interrupt Request Latch

This block raises a single interrupt request toward a processor from two unrelated sources. The first is an internal free-running divider. It emits a one-cycle tick every 2.77 ms, which paces refresh of a multiplexed display. The second is an external pulse from the power supply that marks the start of each mains half cycle. Either event sets one sticky request flip-flop, and that flip-flop drives the processor's interrupt input.

The request stays asserted until the service routine acknowledges it. It does so by pulsing the seventh I/O select line, which arrives here as an asynchronous input. Both external inputs pass through a synchroniser and a rising-edge detector before they act. A line held high therefore counts as one event, not as a level. When a set event and a clear event land in the same cycle, the set wins, so no request is dropped. The divider's terminal count comes from a clock-frequency parameter and is rounded to the nearest whole cycle.

Top module: `tick_mains_irq`

## Requirements
- R1: While `rst_n` is low, `irq` and `tick` are 0. After release, the first `tick` appears exactly TICKS clock edges later, so reset restarts the divider.
- R2: `tick` is high for one cycle and repeats every TICKS cycles, where TICKS = round(CLK_HZ × PERIOD_NS / 1e9). With CLK_HZ = 10000 and the default 2.77 ms period, TICKS is 28.
- R3: On the clock edge that follows a cycle with `tick` high, `irq` becomes 1.
- R4: A rising edge on `mains_pulse` sets `irq` SYNC_STAGES+1 clock edges after the input is first sampled high. Holding the input high causes only one set event.
- R5: Once set, `irq` stays 1 until a rising edge on `ack_sel7`. That edge clears it SYNC_STAGES+1 edges after the input is first sampled high, provided no set event occurs in the same cycle.
- R6: If a set event and an acknowledge edge are detected in the same cycle, `irq` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| mains_pulse | input | 1 | Asynchronous mains half-cycle start pulse |
| ack_sel7 | input | 1 | Asynchronous acknowledge from I/O select line 7 |
| tick | output | 1 | One-cycle periodic timer pulse |
| irq | output | 1 | Sticky interrupt request to the processor |

## Verification
The bench sets CLK_HZ to 10000 and leaves the period at 2.77 ms. This gives a terminal count of 28, which is short enough to observe many timer wraps in one run. Because 27.7 rounds up, the same setting also tests the rounding rule. SYNC_STAGES stays at 2, so both input latencies are three edges. With a period this short, the bench can align directed cases to a tick and finish them before the next tick. Random toggling of both inputs can then drive set and clear events into the same cycles as the timer pulse.

// File: rtl/tick_mains_irq.sv
`timescale 1ns/1ps
module tick_mains_irq #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PERIOD_NS   = 2_770_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mains_pulse,
  input  logic ack_sel7,
  output logic tick,
  output logic irq
);
  localparam longint TICKS_L = (longint'(CLK_HZ) * longint'(PERIOD_NS) + 64'sd500_000_000)
                               / 64'sd1_000_000_000;
  localparam int TICKS = int'(TICKS_L);
  localparam int CW    = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0]          cnt;
  logic [SYNC_STAGES-1:0] m_sync, a_sync;
  logic                   m_prev, a_prev;
  logic                   mains_rise, ack_rise, set_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_sync <= '0;
      a_sync <= '0;
      m_prev <= 1'b0;
      a_prev <= 1'b0;
    end else begin
      m_sync <= {m_sync[SYNC_STAGES-2:0], mains_pulse};
      a_sync <= {a_sync[SYNC_STAGES-2:0], ack_sel7};
      m_prev <= m_sync[SYNC_STAGES-1];
      a_prev <= a_sync[SYNC_STAGES-1];
    end
  end

  assign mains_rise = m_sync[SYNC_STAGES-1] & ~m_prev;
  assign ack_rise   = a_sync[SYNC_STAGES-1] & ~a_prev;
  assign set_evt    = tick | mains_rise;

  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (set_evt)  irq <= 1'b1;
    else if (ack_rise) irq <= 1'b0;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R2
  AST_TICK_SETS:   assert property (@(posedge clk) disable iff (!rst_n) tick |=> irq); // R3
  AST_EDGE_ONCE:   assert property (@(posedge clk) disable iff (!rst_n) mains_rise |=> !mains_rise); // R4
  AST_HOLD:        assert property (@(posedge clk) disable iff (!rst_n) (irq && !ack_rise) |=> irq); // R5
  AST_CLEAR:       assert property (@(posedge clk) disable iff (!rst_n)
                                    (ack_rise && !tick && !mains_rise) |=> !irq); // R5
  AST_SET_WINS:    assert property (@(posedge clk) disable iff (!rst_n)
                                    (mains_rise && ack_rise) |=> irq); // R6
endmodule

// File: tb/tb_tick_mains_irq.sv
`timescale 1ns/1ps
module tb_tick_mains_irq;
  localparam int CLK_HZ = 10_000;
  localparam int SYNC   = 2;
  localparam int T      = $rtoi(CLK_HZ * 2.77e-3 + 0.5);

  logic clk = 1'b0, rst_n = 1'b0, mains = 1'b0, ack = 1'b0;
  logic tick, irq;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  tick_mains_irq #(.CLK_HZ(CLK_HZ), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .mains_pulse(mains), .ack_sel7(ack), .tick(tick), .irq(irq));

  always #2.5 clk = ~clk;

  logic [SYNC+1:0] mh, ah;
  int   ec;
  logic e_tick, e_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = '0; ah = '0; ec = 0; e_tick = 0; e_irq = 0;
    end else begin
      ec++;
      mh = {mh[SYNC:0], mains};
      ah = {ah[SYNC:0], ack};
      if (e_tick || (mh[SYNC] && !mh[SYNC+1])) e_irq = 1'b1;
      else if (ah[SYNC] && !ah[SYNC+1])        e_irq = 1'b0;
      e_tick = (ec % T == 0);
    end
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2", tick, e_tick);
      check("R5", irq, e_irq);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic wait_tick();
    int k = 0;
    do begin @(negedge clk); k++; end while (!tick && k < 4 * T);
  endtask

  initial begin
    #(5ns * 100_000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check("R1", irq, 0);
    check("R1", tick, 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 4 * T);
    check("R1", n, T);
    @(negedge clk);
    check("R2", tick, 0);
    check("R3", irq, 1);
    n = 1;
    do begin @(negedge clk); n++; end while (!tick && n < 4 * T);
    check("R2", n, T);

    @(negedge clk);
    check("R5", irq, 1);
    ack = 1'b1;
    repeat (SYNC) @(negedge clk);
    check("R5", irq, 1);
    @(negedge clk);
    check("R5", irq, 0);
    ack = 1'b0;
    repeat (3) @(negedge clk);
    mains = 1'b1;
    repeat (SYNC) @(negedge clk);
    check("R4", irq, 0);
    @(negedge clk);
    check("R4", irq, 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    repeat (SYNC) @(negedge clk);
    check("R5", irq, 0);
    repeat (4) @(negedge clk);
    check("R4", irq, 0);
    mains = 1'b0;

    wait_tick();
    @(negedge clk);
    check("R3", irq, 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    check("R5", irq, 0);
    ack = 1'b1;
    mains = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    check("R6", irq, 1);
    repeat (3) @(negedge clk);
    check("R6", irq, 1);
    ack = 1'b0;
    mains = 1'b0;

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 8 == 0)  mains = ~mains;
      if ($urandom % 11 == 0) ack = ~ack;
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule